// File: doc/BRIEF.md
# Syndrome-Trellis Viterbi Decoder for Short Block Codes

This block performs hard-decision maximum-likelihood decoding of a short binary linear block code of length N with K data bits. It walks the code's syndrome trellis. Each trellis state is an (N−K)-bit partial syndrome. A 0 bit keeps the state unchanged. A 1 bit XORs the state with the parity-check column of that position. The columns come from a parameter and are held in a small internal table.

One received log-likelihood value enters per accepted beat of a valid/ready stream. Each accepted value advances all 2^(N−K) path metrics by one trellis step in a single clock. The metric step starts with a column-controlled butterfly shuffle and ends with one add-compare-select unit per state. One survivor decision bit is stored for every state and step. Once the last value of a block is in, a traceback walk starts from the all-zero state. It recovers the N decoded bits, one position per cycle, and presents them for a single cycle.

Top module: `trellis_vd`

## Requirements
- R1: While reset is held and right after it is released, out_valid is 0 and in_ready is 1.
- R2: A value is consumed only in a cycle where in_valid and in_ready are both 1. Idle cycles between beats of a block have no effect on the decoded word.
- R3: After the N-th accepted value of a block, in_ready is 0 for exactly N cycles. out_valid is 1 for the single cycle that follows, and in_ready is 1 again in that same cycle.
- R4: Every output word is a code word. Bit k of out_bits (bit 0 is the first value received) selects column k, and the XOR of the selected columns is zero. Column k is H_COLS[k*(N−K) +: N−K]. The default columns for k = 0..6 are 1, 2, 3, 1, 2, 3, 1.
- R5: The output word maximises the sum of the received values over its 1 positions, taken over all code words. When exactly one code word reaches that maximum, the output is that word.
- R6: On equal path metrics the bit-0 branch is kept, so a block of all-zero values decodes to the all-zero word.
- R7: A positive value favours bit 1. A block with +7 wherever a code word has a 1 and −8 wherever it has a 0 decodes to that code word.
- R8: Path metrics wrap modulo 2^METRIC_W and are compared on their wrapped difference. This gives exact results whenever N·2^(LLR_W−1) < 2^(METRIC_W−1), including blocks made only of the extreme values −8 or +7.
- R9: Each block starts from fresh metrics: state 0 at zero and every other state unreachable. Back-to-back blocks are decoded independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A received value is offered |
| in_ready | output | 1 | Decoder can take a value (low while tracing back) |
| in_llr | input | LLR_W | Signed received value; positive favours bit 1 |
| out_valid | output | 1 | One-cycle strobe for a decoded word |
| out_bits | output | N | Decoded word, bit k for position k |

## Verification
On every clock, the bound checker confirms that the output strobe lasts one cycle and coincides with in_ready being high. It also confirms that each emitted word has a zero syndrome, that in_ready drops only after a whole block has been taken, and that it stays low for exactly N cycles. Whether the word is actually the most likely one cannot be seen from a single cycle. The bench shows it by comparing each result against an exhaustive search over every code word. It also uses directed blocks for the tie rule, strong code-word patterns, extreme values that stress the wrapped metrics, and streams with random idle gaps and no gaps at all.

// File: rtl/tvd_pkg.sv
package tvd_pkg;
  typedef enum logic {PH_FILL = 1'b0, PH_WALK = 1'b1} phase_e;

  localparam int unsigned DEF_N = 7;
  localparam int unsigned DEF_K = 5;
  // columns k6..k0 = 1,3,2,1,3,2,1 (each 2 bits)
  localparam logic [13:0] DEF_H = 14'b01_11_10_01_11_10_01;
endpackage

// File: rtl/tvd_col_rom.sv
module tvd_col_rom #(
  parameter int unsigned N = 7,
  parameter int unsigned R = 2,
  parameter logic [N*R-1:0] H_COLS = '0,
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [R-1:0]     col
);
  always_comb begin
    col = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (idx == IDX_W'(i)) col = H_COLS[i*R +: R];
    end
  end
endmodule

// File: rtl/tvd_perm.sv
module tvd_perm #(
  parameter int unsigned R  = 2,
  parameter int unsigned DW = 8,
  localparam int unsigned M = 1 << R
) (
  input  logic [R-1:0]  ctrl,
  input  logic [DW-1:0] din  [M],
  output logic [DW-1:0] dout [M]
);
  // stage j swaps the pair whose indices differ in bit j when ctrl[j] is set,
  // so dout[s] = din[s ^ ctrl]
  logic [DW-1:0] stg [R+1][M];

  genvar gi, gj;
  generate
    for (gi = 0; gi < M; gi++) begin : g_in
      assign stg[0][gi] = din[gi];
      assign dout[gi]   = stg[R][gi];
    end
    for (gj = 0; gj < R; gj++) begin : g_stage
      for (gi = 0; gi < M; gi++) begin : g_sw
        localparam int unsigned PEER = gi ^ (1 << gj);
        assign stg[gj+1][gi] = ctrl[gj] ? stg[gj][PEER] : stg[gj][gi];
      end
    end
  endgenerate
endmodule

// File: rtl/tvd_acs.sv
module tvd_acs #(
  parameter int unsigned W  = 7,
  parameter int unsigned LW = 4
) (
  input  logic [W-1:0]        m_stay,
  input  logic                reach_stay,
  input  logic [W-1:0]        m_cross,
  input  logic                reach_cross,
  input  logic signed [LW-1:0] llr,
  output logic [W-1:0]        m_out,
  output logic                reach_out,
  output logic                dec
);
  logic [W-1:0] cand;
  logic [W-1:0] diff;
  logic         cross_wins;

  always_comb begin
    cand       = m_cross + {{(W-LW){llr[LW-1]}}, llr};
    diff       = cand - m_stay;
    // wrapped compare: strictly greater only, ties keep the bit-0 branch
    cross_wins = reach_cross && (!reach_stay || (!diff[W-1] && (diff != '0)));
    m_out      = cross_wins ? cand : m_stay;
    reach_out  = reach_stay | reach_cross;
    dec        = cross_wins;
  end
endmodule

// File: rtl/tvd_trace.sv
module tvd_trace
  import tvd_pkg::*;
#(
  parameter int unsigned N = 7,
  parameter int unsigned R = 2,
  parameter logic [N*R-1:0] H_COLS = '0,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned M = 1 << R
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [M-1:0]     wr_dec,
  input  logic             start,
  output logic             busy,
  output logic             out_valid,
  output logic [N-1:0]     out_bits
);
  logic [M-1:0]     surv_q [N];
  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] k_q, k_d;
  logic [R-1:0]     st_q, st_d;
  logic [N-1:0]     bits_q, bits_d;
  logic             ov_q, ov_d;
  logic [R-1:0]     col;
  logic             bit_now;

  tvd_col_rom #(.N(N), .R(R), .H_COLS(H_COLS), .IDX_W(IDX_W)) u_rom (
    .idx (k_q),
    .col (col)
  );

  // survivor store: written once per accepted step, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) surv_q[wr_idx] <= wr_dec;
  end

  assign bit_now = surv_q[k_q][st_q];

  always_comb begin
    phase_d = phase_q;
    k_d     = k_q;
    st_d    = st_q;
    bits_d  = bits_q;
    ov_d    = 1'b0;
    case (phase_q)
      PH_FILL: begin
        if (start) begin
          phase_d = PH_WALK;
          k_d     = IDX_W'(N - 1);
          st_d    = '0;
        end
      end
      default: begin
        bits_d[k_q] = bit_now;
        if (bit_now) st_d = st_q ^ col;
        if (k_q == '0) begin
          phase_d = PH_FILL;
          ov_d    = 1'b1;
        end else begin
          k_d = k_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_FILL;
      k_q     <= '0;
      st_q    <= '0;
      bits_q  <= '0;
      ov_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      k_q     <= k_d;
      st_q    <= st_d;
      bits_q  <= bits_d;
      ov_q    <= ov_d;
    end
  end

  assign busy      = (phase_q == PH_WALK);
  assign out_valid = ov_q;
  assign out_bits  = bits_q;
endmodule

// File: rtl/trellis_vd.sv
module trellis_vd
  import tvd_pkg::*;
#(
  parameter int unsigned N        = DEF_N,
  parameter int unsigned K        = DEF_K,
  parameter int unsigned LLR_W    = 4,
  parameter int unsigned METRIC_W = 7,
  parameter logic [N*(N-K)-1:0] H_COLS = DEF_H
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [LLR_W-1:0] in_llr,
  output logic                    out_valid,
  output logic [N-1:0]            out_bits
);
  localparam int unsigned R     = N - K;
  localparam int unsigned M     = 1 << R;
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned W     = METRIC_W;
  localparam logic [M-1:0] REACH_INIT = M'(1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [IDX_W-1:0] step_q, step_d;
  logic [W-1:0]     met_q [M];
  logic [W-1:0]     met_d [M];
  logic [M-1:0]     reach_q, reach_d;
  logic [W-1:0]     acs_m [M];
  logic [M-1:0]     acs_r;
  logic [M-1:0]     dec;
  logic [W:0]       pin  [M];
  logic [W:0]       pout [M];
  logic [R-1:0]     col;
  logic             acc, last, busy;

  assign in_ready = !busy;
  assign acc      = in_valid && in_ready;
  assign last     = acc && (step_q == IDX_W'(N - 1));

  tvd_col_rom #(.N(N), .R(R), .H_COLS(H_COLS), .IDX_W(IDX_W)) u_rom (
    .idx (step_q),
    .col (col)
  );

  tvd_perm #(.R(R), .DW(W + 1)) u_perm (
    .ctrl (col),
    .din  (pin),
    .dout (pout)
  );

  genvar gs;
  generate
    for (gs = 0; gs < M; gs++) begin : g_state
      assign pin[gs] = {reach_q[gs], met_q[gs]};
      tvd_acs #(.W(W), .LW(LLR_W)) u_acs (
        .m_stay      (met_q[gs]),
        .reach_stay  (reach_q[gs]),
        .m_cross     (pout[gs][W-1:0]),
        .reach_cross (pout[gs][W]),
        .llr         (in_llr),
        .m_out       (acs_m[gs]),
        .reach_out   (acs_r[gs]),
        .dec         (dec[gs])
      );
    end
  endgenerate

  always_comb begin
    step_d  = step_q;
    reach_d = reach_q;
    for (int i = 0; i < int'(M); i++) met_d[i] = met_q[i];
    if (acc) begin
      if (last) begin
        step_d  = '0;
        reach_d = REACH_INIT;
        for (int i = 0; i < int'(M); i++) met_d[i] = '0;
      end else begin
        step_d  = step_q + 1'b1;
        reach_d = acs_r;
        for (int i = 0; i < int'(M); i++) met_d[i] = acs_m[i];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      step_q  <= '0;
      reach_q <= REACH_INIT;
      for (int i = 0; i < int'(M); i++) met_q[i] <= '0;
    end else begin
      step_q  <= step_d;
      reach_q <= reach_d;
      for (int i = 0; i < int'(M); i++) met_q[i] <= met_d[i];
    end
  end

  tvd_trace #(.N(N), .R(R), .H_COLS(H_COLS), .IDX_W(IDX_W)) u_trace (
    .clk       (clk),
    .srst_n    (srst_n),
    .wr_en     (acc),
    .wr_idx    (step_q),
    .wr_dec    (dec),
    .start     (last),
    .busy      (busy),
    .out_valid (out_valid),
    .out_bits  (out_bits)
  );
endmodule

// File: rtl/tvd_check.sv
module tvd_check #(
  parameter int unsigned N = 7,
  parameter int unsigned R = 2,
  parameter logic [N*R-1:0] H_COLS = '0
) (
  input logic         clk,
  input logic         srst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [N-1:0] out_bits
);
  logic [R-1:0] syn;
  int unsigned  acc_cnt;
  int unsigned  low_cnt;

  always_comb begin
    syn = '0;
    for (int i = 0; i < int'(N); i++) if (out_bits[i]) syn ^= H_COLS[i*R +: R];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc_cnt <= 0;
      low_cnt <= 0;
    end else begin
      if (in_valid && in_ready) acc_cnt <= (acc_cnt == N - 1) ? 0 : acc_cnt + 1;
      low_cnt <= in_ready ? 0 : low_cnt + 1;
    end
  end

  p_strobe_once_r3: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |=> !out_valid);
  p_strobe_ready_r3: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> in_ready);
  p_walk_len_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(in_ready) |-> (low_cnt == N));
  p_block_full_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(in_ready) |-> (acc_cnt == 0));
  p_codeword_r4: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> (syn == '0));
endmodule

bind trellis_vd tvd_check #(.N(N), .R(N - K), .H_COLS(H_COLS)) u_check (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bits  (out_bits)
);

// File: tb/test_trellis_vd.sv
module test_trellis_vd;
  localparam int CLK_P = 10;
  localparam int N  = 7;
  localparam int K  = 5;
  localparam int R  = N - K;
  localparam int LW = 4;
  localparam logic [N*R-1:0] H = 14'b01_11_10_01_11_10_01;

  logic clk, rst_n, in_valid, in_ready, out_valid;
  logic signed [LW-1:0] in_llr;
  logic [N-1:0] out_bits;

  trellis_vd #(.N(N), .K(K), .LLR_W(LW), .METRIC_W(7), .H_COLS(H)) i_trellis_vd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .out_valid(out_valid), .out_bits(out_bits)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int errs = 0, checks = 0;
  bit started = 0;
  int blk_q[$];
  int exp_q[$];
  string tag_q[$];

  function automatic logic [R-1:0] syn(logic [N-1:0] w);
    logic [R-1:0] s = '0;
    for (int i = 0; i < N; i++) if (w[i]) s ^= H[i*R +: R];
    return s;
  endfunction

  function automatic int wmet(logic [N-1:0] w, int y[N]);
    int s = 0;
    for (int i = 0; i < N; i++) if (w[i]) s += y[i];
    return s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural cycle model of the handshake and output timing
  bit mr, mv;
  int cnt, left;
  int cur[N];
  always @(posedge clk) begin
    if (!rst_n) begin
      mr <= 1; mv <= 0; cnt <= 0; left <= 0;
    end else begin
      mv <= 0;
      if (left > 0) begin
        left <= left - 1;
        if (left == 1) begin mr <= 1; mv <= 1; end
      end else if (in_valid && mr) begin
        cur[cnt] = int'(in_llr);
        if (cnt == N - 1) begin
          for (int i = 0; i < N; i++) blk_q.push_back(cur[i]);
          cnt <= 0; mr <= 0; left <= N;
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic check_block();
    int y[N];
    int best, nbest, e, m;
    logic [N-1:0] bw;
    string tg;
    for (int i = 0; i < N; i++) y[i] = blk_q.pop_front();
    e = exp_q.pop_front();
    tg = tag_q.pop_front();
    best = -100000; nbest = 0; bw = '0;
    for (int w = 0; w < (1 << N); w++) begin
      if (syn(N'(w)) == '0) begin
        m = wmet(N'(w), y);
        if (m > best) begin best = m; nbest = 1; bw = N'(w); end
        else if (m == best) nbest++;
      end
    end
    chk(syn(out_bits) == '0, "R4 syndrome of output", int'(syn(out_bits)), 0);
    chk(wmet(out_bits, y) == best, "R5 metric of output", wmet(out_bits, y), best);
    if (e >= 0) chk(out_bits == N'(e), tg, int'(out_bits), e);
    else if (nbest == 1) chk(out_bits == bw, "R5 unique ML word", int'(out_bits), int'(bw));
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(in_ready === mr, "R2 R3 in_ready vs model", int'(in_ready), int'(mr));
      chk(out_valid === mv, "R3 out_valid vs model", int'(out_valid), int'(mv));
      if (mv && out_valid === 1'b1) check_block();
    end
  end

  task automatic send_beat(int v);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_llr   = LW'(v);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_block(int y[N], int gapmax, int e, string tg);
    exp_q.push_back(e);
    tag_q.push_back(tg);
    for (int k = 0; k < N; k++) begin
      if (gapmax > 0) repeat ($urandom_range(0, gapmax)) @(negedge clk);
      send_beat(y[k]);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    errs++; checks++;
    $display("FAIL watchdog R3: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int y[N];
    int ncw;
    rst_n = 0; in_valid = 0; in_llr = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    started = 1;

    // R6: all ties resolve to bit 0
    for (int i = 0; i < N; i++) y[i] = 0;
    send_block(y, 0, 0, "R6 zero values give zero word");

    // R7: strong code-word patterns
    ncw = 0;
    for (int w = 0; w < (1 << N) && ncw < 8; w++) begin
      if (syn(N'(w)) == '0 && (w % 3 == 0 || w == 0)) begin
        for (int i = 0; i < N; i++) y[i] = w[i] ? 7 : -8;
        send_block(y, 1, w, "R7 strong pattern gives that word");
        ncw++;
      end
    end

    // R8: extreme values stress wrapped metrics
    for (int i = 0; i < N; i++) y[i] = -8;
    send_block(y, 0, 0, "R8 all negative extreme");
    for (int i = 0; i < N; i++) y[i] = 7;
    send_block(y, 0, -1, "R8 all positive extreme");
    for (int i = 0; i < N; i++) y[i] = (i % 2) ? 7 : -8;
    send_block(y, 0, -1, "R8 alternating extreme");

    // R2, R5, R9: random blocks with gaps, then back-to-back
    for (int b = 0; b < 30; b++) begin
      for (int i = 0; i < N; i++) y[i] = int'($urandom_range(0, 15)) - 8;
      send_block(y, 3, -1, "R2 gapped random");
    end
    for (int b = 0; b < 30; b++) begin
      for (int i = 0; i < N; i++) y[i] = int'($urandom_range(0, 15)) - 8;
      send_block(y, 0, -1, "R9 back-to-back random");
    end

    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule